// File: doc/BRIEF.md
# Performance Floor Arbiter

This block merges performance-floor requests from nine client ports into one effective minimum operating level for a shared bus. A client acquires a floor at a chosen level or releases the floor it holds. For each client the block keeps a held flag and a stored level. The output floor is the most demanding level among the current holders. Levels run from 0 to 2, and a smaller number means more performance.

Requests arrive on a valid/ready channel. Ready is always high, and exactly one operation is taken per cycle, so there is never a race between clients. Each accepted operation returns a registered response code in the next cycle. An acquire that pushes the floor to a smaller level also raises a one-cycle transition request that carries the new level. A release only recomputes the floor and never starts a transition. Regulators, clock dividers and the load governor sit outside the block and consume the floor and the transition pulse.

An `enable` input marks the service as available. While it is low, every operation is refused.

Top module: `perf_floor_arb`

## Requirements
- R1: `req_ready` is always 1. Every cycle with `req_valid` high gives `rsp_valid` high in the next cycle, with `rsp_code` for that operation. Otherwise `rsp_valid` is 0.
- R2: There are nine clients, ids 0 to 8, each with a held flag and a stored level. `floor_level` equals the smallest stored level among the held clients. Level 0 is the highest performance and level 2 the lowest.
- R3: When no client holds a request, `floor_level` is 2.
- R4: An acquire (`req_acquire`=1) from a client that already holds a request returns code 01. It changes no state and raises no transition, even when its level is smaller than the floor.
- R5: A release (`req_acquire`=0) returns code 00. It clears the client's flag and resets its level to 2, and `floor_level` shows the value recomputed over the remaining holders in the next cycle. A release of a client that holds nothing changes nothing.
- R6: A release never raises `xfer_req`.
- R7: An accepted acquire whose level is smaller than the current floor raises `xfer_req` for exactly one cycle, with `xfer_level` equal to that level. `floor_level` takes the same value in the same cycle. An accepted acquire at a level equal to or above the floor raises no transition and leaves the floor unchanged.
- R8: While `enable` is 0, every operation returns code 10 and changes no state.
- R9: An id of 9 or more, or an acquire with a level of 3, returns code 11 and changes no state. When several errors apply, code 10 takes priority over 11, and 11 over 01.
- R10: After reset, `rsp_valid` and `xfer_req` are 0, `floor_level` is 2 and no client holds a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Service available; when low, all operations are refused |
| req_valid | input | 1 | Operation present |
| req_ready | output | 1 | Always 1; one operation is taken per cycle |
| req_acquire | input | 1 | 1 = acquire, 0 = release |
| req_id | input | 4 | Client id |
| req_level | input | 2 | Requested level (acquire only) |
| rsp_valid | output | 1 | Response present (one cycle after the operation) |
| rsp_code | output | 2 | 00 ok, 01 already held, 10 unavailable, 11 bad argument |
| floor_level | output | 2 | Effective floor level |
| xfer_req | output | 1 | One-cycle transition request |
| xfer_level | output | 2 | Target level of the transition |

## Verification
Two functions can land in the same cycle: tightening the floor and rejecting a duplicate. This happens when a client that already holds a lenient level acquires again at a more demanding level. The bench provokes it for every client. It expects code 01 with no pulse and an unchanged floor, because the rejection must suppress the transition. The bench also covers two other collisions: an out-of-range id while the service is disabled, and a release of the very client that sets the floor. In each case a model in the bench computes the floor and the code.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  typedef enum logic [1:0] {
    RSP_OK     = 2'b00,
    RSP_HELD   = 2'b01,
    RSP_OFF    = 2'b10,
    RSP_BADARG = 2'b11
  } rsp_code_e;
endpackage

// File: rtl/pfa_ctrl.sv
module pfa_ctrl #(
  parameter int NUM_CLIENTS = 9,
  parameter int NUM_LEVELS  = 3,
  localparam int ID_W  = $clog2(NUM_CLIENTS),
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                   enable,
  input  logic                   req_valid,
  input  logic                   req_acquire,
  input  logic [ID_W-1:0]        req_id,
  input  logic [LVL_W-1:0]       req_level,
  input  logic [NUM_CLIENTS-1:0] held_q,
  input  logic [LVL_W-1:0]       floor_q,
  output logic [NUM_CLIENTS-1:0] set_vec,
  output logic [NUM_CLIENTS-1:0] clr_vec,
  output pfa_pkg::rsp_code_e     code_d,
  output logic                   tighten
);
  import pfa_pkg::*;

  function automatic logic id_in_range(input logic [ID_W-1:0] id);
    return 32'(id) < 32'(NUM_CLIENTS);
  endfunction

  function automatic logic lvl_in_range(input logic [LVL_W-1:0] lvl);
    return 32'(lvl) < 32'(NUM_LEVELS);
  endfunction

  function automatic logic is_tighter(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] cur);
    return lvl < cur;
  endfunction

  logic [NUM_CLIENTS-1:0] id_hot;
  logic                   cur_held;
  logic                   go;

  always_comb begin
    for (int i = 0; i < NUM_CLIENTS; i++) id_hot[i] = (req_id == ID_W'(i));
  end

  assign cur_held = |(held_q & id_hot);

  always_comb begin
    if (!enable)                                                code_d = RSP_OFF;
    else if (!id_in_range(req_id) || (req_acquire && !lvl_in_range(req_level)))
                                                                code_d = RSP_BADARG;
    else if (req_acquire && cur_held)                           code_d = RSP_HELD;
    else                                                        code_d = RSP_OK;
  end

  assign go      = req_valid && (code_d == RSP_OK);
  assign set_vec = (go && req_acquire)  ? id_hot : '0;
  assign clr_vec = (go && !req_acquire) ? id_hot : '0;
  assign tighten = go && req_acquire && is_tighter(req_level, floor_q);
endmodule

// File: rtl/pfa_client_table.sv
module pfa_client_table #(
  parameter int NUM_CLIENTS = 9,
  parameter int NUM_LEVELS  = 3,
  localparam int LVL_W = $clog2(NUM_LEVELS),
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS - 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CLIENTS-1:0]             set_vec,
  input  logic [NUM_CLIENTS-1:0]             clr_vec,
  input  logic [LVL_W-1:0]                   wr_level,
  output logic [NUM_CLIENTS-1:0]             held_q,
  output logic [NUM_CLIENTS-1:0]             held_d,
  output logic [NUM_CLIENTS-1:0][LVL_W-1:0]  lvl_d
);
  logic [NUM_CLIENTS-1:0][LVL_W-1:0] lvl_q;

  for (genvar g = 0; g < NUM_CLIENTS; g++) begin : g_client
    assign held_d[g] = set_vec[g] | (held_q[g] & ~clr_vec[g]);
    assign lvl_d[g]  = set_vec[g] ? wr_level : (clr_vec[g] ? LVL_MAX : lvl_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q[g] <= 1'b0;
        lvl_q[g]  <= LVL_MAX;
      end else begin
        held_q[g] <= held_d[g];
        lvl_q[g]  <= lvl_d[g];
      end
    end
  end

  // R4: the controller never sets a client that already holds a floor
  a_r4_no_reacquire: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec & held_q) == '0);
  // R1: at most one client is touched per cycle
  a_r1_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec | clr_vec));
endmodule

// File: rtl/pfa_min_tree.sv
module pfa_min_tree #(
  parameter int NUM_CLIENTS = 9,
  parameter int NUM_LEVELS  = 3,
  localparam int LVL_W = $clog2(NUM_LEVELS),
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS - 1)
) (
  input  logic [NUM_CLIENTS-1:0]            held,
  input  logic [NUM_CLIENTS-1:0][LVL_W-1:0] lvls,
  output logic [LVL_W-1:0]                  floor_d
);
  function automatic logic [LVL_W-1:0] pick_min(input logic [LVL_W-1:0] a,
                                                input logic [LVL_W-1:0] b);
    return (b < a) ? b : a;
  endfunction

  always_comb begin
    floor_d = LVL_MAX;
    for (int i = 0; i < NUM_CLIENTS; i++)
      if (held[i]) floor_d = pick_min(floor_d, lvls[i]);
  end
endmodule

// File: rtl/perf_floor_arb.sv
module perf_floor_arb #(
  parameter int NUM_CLIENTS = 9,
  parameter int NUM_LEVELS  = 3,
  localparam int ID_W  = $clog2(NUM_CLIENTS),
  localparam int LVL_W = $clog2(NUM_LEVELS),
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_acquire,
  input  logic [ID_W-1:0]  req_id,
  input  logic [LVL_W-1:0] req_level,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic [LVL_W-1:0] floor_level,
  output logic             xfer_req,
  output logic [LVL_W-1:0] xfer_level
);
  import pfa_pkg::*;

  logic [NUM_CLIENTS-1:0]            set_vec, clr_vec, held_q, held_d;
  logic [NUM_CLIENTS-1:0][LVL_W-1:0] lvl_d;
  logic [LVL_W-1:0]                  floor_d;
  rsp_code_e                         code_d;
  logic                              tighten;

  assign req_ready = 1'b1;

  pfa_ctrl #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_LEVELS(NUM_LEVELS)) ctrl_i (
    .enable(enable), .req_valid(req_valid), .req_acquire(req_acquire),
    .req_id(req_id), .req_level(req_level), .held_q(held_q),
    .floor_q(floor_level), .set_vec(set_vec), .clr_vec(clr_vec),
    .code_d(code_d), .tighten(tighten));

  pfa_client_table #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_LEVELS(NUM_LEVELS)) table_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .wr_level(req_level), .held_q(held_q), .held_d(held_d), .lvl_d(lvl_d));

  pfa_min_tree #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_LEVELS(NUM_LEVELS)) min_i (
    .held(held_d), .lvls(lvl_d), .floor_d(floor_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_level <= LVL_MAX;
      rsp_valid   <= 1'b0;
      rsp_code    <= RSP_OK;
      xfer_req    <= 1'b0;
      xfer_level  <= LVL_MAX;
    end else begin
      floor_level <= floor_d;
      rsp_valid   <= req_valid;
      rsp_code    <= code_d;
      xfer_req    <= tighten;
      if (tighten) xfer_level <= req_level;
    end
  end

  // R7: a transition pulse always agrees with the floor it produced
  a_r7_pulse_matches_floor: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (floor_level == xfer_level));
  // R6: releases never start a transition
  a_r6_release_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_acquire) |=> !xfer_req);
  // R3: no holders means the lenient default floor
  a_r3_idle_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q == '0) |-> (floor_level == LVL_MAX));
  // R8: disabled service refuses and leaves the floor alone
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !enable) |=> (rsp_code == RSP_OFF) && $stable(floor_level));
  // R1: a response follows each operation
  a_r1_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/perf_floor_arb_tb.sv
module perf_floor_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_acquire = 1'b0;
  logic [3:0] req_id = '0;
  logic [1:0] req_level = '0;
  logic       rsp_valid;
  logic [1:0] rsp_code;
  logic [1:0] floor_level;
  logic       xfer_req;
  logic [1:0] xfer_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit       m_held [9];
  int       m_lvl  [9];
  int       m_floor = 2;

  always #2.5 clk = ~clk;

  perf_floor_arb dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
    .req_ready(req_ready), .req_acquire(req_acquire), .req_id(req_id),
    .req_level(req_level), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .floor_level(floor_level), .xfer_req(xfer_req), .xfer_level(xfer_level));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_floor();
    int m = 2;
    for (int i = 0; i < 9; i++) if (m_held[i] && m_lvl[i] < m) m = m_lvl[i];
    return m;
  endfunction

  // Called at a negedge; checks results at the following negedge.
  task automatic op(input bit acq, input int id, input int lvl, input string tag);
    int  code;
    bit  pulse;
    req_valid = 1'b1; req_acquire = acq; req_id = 4'(id); req_level = 2'(lvl);
    if (!enable) code = 2;
    else if (id >= 9 || (acq && lvl >= 3)) code = 3;
    else if (acq && m_held[id]) code = 1;
    else code = 0;
    pulse = (code == 0) && acq && (lvl < m_floor);
    if (code == 0) begin
      if (acq) begin m_held[id] = 1; m_lvl[id] = lvl; end
      else     begin m_held[id] = 0; m_lvl[id] = 2; end
    end
    m_floor = model_floor();
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b1, tag, "req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b1, tag, "rsp_valid", int'(rsp_valid), 1);
    chk(int'(rsp_code) == code, tag, "rsp_code", int'(rsp_code), code);
    chk(int'(floor_level) == m_floor, tag, "floor_level", int'(floor_level), m_floor);
    chk(xfer_req == pulse, tag, "xfer_req", int'(xfer_req), int'(pulse));
    if (pulse) chk(int'(xfer_level) == lvl, tag, "xfer_level", int'(xfer_level), lvl);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(rsp_valid == 1'b0, tag, "rsp_valid idle", int'(rsp_valid), 0);
    chk(xfer_req == 1'b0, tag, "xfer_req idle", int'(xfer_req), 0);
    chk(int'(floor_level) == m_floor, tag, "floor idle", int'(floor_level), m_floor);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) begin m_held[i] = 0; m_lvl[i] = 2; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rsp_valid == 1'b0, "R10", "rsp_valid", int'(rsp_valid), 0);
    chk(xfer_req == 1'b0, "R10", "xfer_req", int'(xfer_req), 0);
    chk(floor_level == 2'd2, "R10", "floor_level", int'(floor_level), 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 disabled: all operations refused, including bad id (priority)
    for (int id = 0; id < 16; id++) op(1'b1, id, 0, "R8");
    op(1'b0, 0, 0, "R8");
    idle("R8");
    enable = 1'b1;
    // R7 / R4 / R5 single-client sweep over every level
    for (int id = 0; id < 9; id++) begin
      for (int lv = 0; lv < 3; lv++) begin
        op(1'b1, id, lv, "R7");
        idle("R7");
        op(1'b1, id, 0, "R4");
        op(1'b0, id, 0, "R5");
        op(1'b0, id, 0, "R5");
      end
    end
    // R4: holder at lenient level retries at demanding level
    for (int id = 0; id < 9; id++) begin
      op(1'b1, id, 2, "R7");
      op(1'b1, id, 0, "R4");
      op(1'b0, id, 0, "R6");
    end
    // R2 / R6: stacked holders, released in several orders
    for (int pat = 0; pat < 3; pat++) begin
      for (int id = 0; id < 9; id++) op(1'b1, id, (id + pat) % 3, "R2");
      op(1'b1, 4, 1, "R4");
      for (int k = 0; k < 9; k++) op(1'b0, (k * (pat + 2)) % 9, 0, "R6");
      idle("R3");
    end
    // R7 equal level: no pulse
    op(1'b1, 1, 1, "R7");
    op(1'b1, 2, 1, "R7");
    op(1'b1, 3, 2, "R7");
    op(1'b1, 5, 0, "R7");
    op(1'b0, 5, 0, "R5");
    op(1'b0, 1, 0, "R5");
    op(1'b0, 2, 0, "R5");
    op(1'b0, 3, 0, "R3");
    // R9 bad arguments
    for (int id = 9; id < 16; id++) op(1'b1, id, 0, "R9");
    for (int id = 0; id < 9; id++) op(1'b1, id, 3, "R9");
    op(1'b0, 12, 0, "R9");
    op(1'b1, 6, 1, "R7");
    op(1'b1, 6, 3, "R9");
    op(1'b0, 6, 3, "R5");
    idle("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule